// File: doc/BRIEF.md
# Double-Rate Pad Driver with Strobe Write Preamble

This block drives one bidirectional data or strobe pad at twice the clock rate. Each clock cycle it takes two single-rate words: one meant for the low half of the period and one meant for the high half. It also takes a single-rate output-enable request. Both words are registered on the rising edge. The low-half word is then moved into a register clocked on the falling edge. The high-half word is moved into a register clocked on the next rising edge. The clock level then picks which of the two registers reaches the pad, so two items leave the pad in every clock period.

The enable path uses the same two-register double-rate structure. Its first stage asserts on a falling edge. Its second stage is active low and asserts on the following rising edge. The pad is driven only while both stages assert enable, so every enabled burst starts with one extra half period of high impedance. That half period is the write preamble a strobe pad needs. For data pads, the integrating design is expected to clock this block from a clock shifted by −90 degrees relative to the strobe clock. That phase shift is made outside the block.

Top module: `ddr_preamble_out`

## Requirements
- R1: While reset is sampled high on a rising edge, the enable output is low in the following half periods and the pad is high impedance. Reset clears every data register to zero and sets the active-low enable stage to its disabled value (1).
- R2: A low-half word sampled on rising edge k is shown on the pad during the low phase that begins at the falling edge half a period after k.
- R3: A high-half word sampled on rising edge k is shown on the pad during the high phase that begins at rising edge k+1.
- R4: The enable output is high only while both enable stages assert. Whenever the enable output is low, the pad value is 'z.
- R5: A request first sampled high on rising edge k turns the enable output high at rising edge k+1. The low-phase slot between k+0.5 and k+1 stays undriven; this is the write preamble.
- R6: When the request is first sampled low on rising edge j, the pad stops being driven at the falling edge j+0.5. No low-phase slot is driven after the last high item of the burst.
- R7: A request that is high on exactly one rising edge drives the pad for exactly one half period. That half period carries the high-half word of the same edge.
- R8: The data registers keep loading while the pad is undriven. The first item driven after an idle gap is the high-half word sampled together with the first request, not an older word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Rising and falling edges are both used. Its level selects the pad item. |
| rst | input | 1 | Synchronous reset, active high |
| loData | input | DW | Word for the low half of the period |
| hiData | input | DW | Word for the high half of the period |
| oeReq | input | 1 | Single-rate output-enable request |
| padData | output | DW | Pad value. It is 'z when not driven. |
| padEn | output | 1 | High while the pad is driven |

## Verification
The assertions assume that the inputs change only between edges, away from both clock edges, so that a value sampled at a falling edge matches the value sampled at the rising edge that follows it. They also assume reset is low for at least two rising edges before any timing check applies. A counter in the checker enforces this second assumption.

The stimulus changes every input one nanosecond after a rising edge. It keeps the request level for several cycles at a time, so that preambles, single pulses and burst ends all occur. Reset is raised only occasionally, and always at that same point in the cycle.

// File: rtl/ddr_preamble_pkg.sv
package ddr_preamble_pkg;

  // Enable-stage outputs that the control passes to the datapath
  typedef struct packed {
    logic earlyOe;   // first stage, updated on the falling edge
    logic lateOeN;   // second stage, active low, updated on the rising edge
  } oeStages_t;

endpackage

// File: rtl/ddr_preamble_oe_ctrl.sv
module ddr_preamble_oe_ctrl
  import ddr_preamble_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      oeReq,
  output oeStages_t stages
);

  logic oeCap;
  logic earlyOe;
  logic lateOeN;

  // Single-rate capture of the request
  always_ff @(posedge clk) begin
    if (rst) oeCap <= 1'b0;
    else     oeCap <= oeReq;
  end

  // First stage: asserts half a period after capture
  always_ff @(negedge clk) begin
    if (rst) earlyOe <= 1'b0;
    else     earlyOe <= oeCap;
  end

  // Second stage, active low: asserts one full period after capture,
  // which holds the pad undriven for one more half period (the preamble)
  always_ff @(posedge clk) begin
    if (rst) lateOeN <= 1'b1;
    else     lateOeN <= ~oeCap;
  end

  assign stages = '{earlyOe: earlyOe, lateOeN: lateOeN};

endmodule

// File: rtl/ddr_preamble_data.sv
module ddr_preamble_data
  import ddr_preamble_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] loData,
  input  logic [DW-1:0] hiData,
  input  oeStages_t     stages,
  output logic [DW-1:0] padWord,
  output logic          padDrive
);

  localparam logic [DW-1:0] ZeroWord = '0;

  logic [DW-1:0] capLo;
  logic [DW-1:0] capHi;
  logic [DW-1:0] retLo;
  logic [DW-1:0] retHi;

  // Both streams load on the same rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      capLo <= ZeroWord;
      capHi <= ZeroWord;
    end else begin
      capLo <= loData;
      capHi <= hiData;
    end
  end

  // Low-half stream is retimed on the falling edge
  always_ff @(negedge clk) begin
    if (rst) retLo <= ZeroWord;
    else     retLo <= capLo;
  end

  // High-half stream is retimed on the rising edge
  always_ff @(posedge clk) begin
    if (rst) retHi <= ZeroWord;
    else     retHi <= capHi;
  end

  // Clock level picks the half
  assign padWord  = clk ? retHi : retLo;
  assign padDrive = stages.earlyOe & ~stages.lateOeN;

endmodule

// File: rtl/ddr_preamble_out.sv
module ddr_preamble_out
  import ddr_preamble_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] loData,
  input  logic [DW-1:0] hiData,
  input  logic          oeReq,
  output wire  [DW-1:0] padData,
  output logic          padEn
);

  oeStages_t     stages;
  logic [DW-1:0] padWord;
  logic          padDrive;

  ddr_preamble_oe_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .oeReq  (oeReq),
    .stages (stages)
  );

  ddr_preamble_data #(.DW(DW)) u_data (
    .clk      (clk),
    .rst      (rst),
    .loData   (loData),
    .hiData   (hiData),
    .stages   (stages),
    .padWord  (padWord),
    .padDrive (padDrive)
  );

  assign padData = padDrive ? padWord : {DW{1'bz}};
  assign padEn   = padDrive;

endmodule

// File: rtl/ddr_preamble_out_chk.sv
module ddr_preamble_out_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] loData,
  input logic [DW-1:0] hiData,
  input logic          oeReq,
  input logic [DW-1:0] padData,
  input logic          padEn
);

  // Counts clean rising edges since reset, saturating at 3
  logic [1:0] cleanCnt;
  always_ff @(posedge clk) begin
    if (rst)                 cleanCnt <= 2'd0;
    else if (cleanCnt != 2'd3) cleanCnt <= cleanCnt + 2'd1;
  end

  // R1: after a reset edge the following low phase is undriven
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !padEn);

  // R2: low phase shows the low word of the previous rising edge
  p_lo_item_r2: assert property (@(posedge clk) disable iff (rst)
    (cleanCnt >= 2'd2 && padEn) |-> padData == $past(loData));

  // R3: high phase shows the high word of the previous rising edge
  p_hi_item_r3: assert property (@(negedge clk) disable iff (rst)
    (cleanCnt >= 2'd2 && padEn) |-> padData == $past(hiData, 2));

  // R5: the low phase is driven only if the request held over two edges
  p_preamble_r5: assert property (@(posedge clk) disable iff (rst)
    (cleanCnt >= 2'd2) |-> padEn == ($past(oeReq) && $past(oeReq, 2)));

  // R6: the high phase is driven exactly when the request was sampled one edge earlier
  p_high_enable_r6: assert property (@(negedge clk) disable iff (rst)
    (cleanCnt >= 2'd2) |-> padEn == $past(oeReq, 2));

endmodule

bind ddr_preamble_out ddr_preamble_out_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .loData  (loData),
  .hiData  (hiData),
  .oeReq   (oeReq),
  .padData (padData),
  .padEn   (padEn)
);

// File: tb/ddr_preamble_out_bench.sv
`timescale 1ns/1ps
module ddr_preamble_out_bench;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] loData = '0;
  logic [DW-1:0] hiData = '0;
  logic          oeReq = 1'b0;
  wire  [DW-1:0] padData;
  logic          padEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  ddr_preamble_out #(.DW(DW)) u_ddr_preamble_out (
    .clk(clk), .rst(rst), .loData(loData), .hiData(hiData),
    .oeReq(oeReq), .padData(padData), .padEn(padEn)
  );

  // Values sampled at the current (c) and earlier rising edges
  logic [DW-1:0] curLo, curHi, prevHi;
  logic curR, capC, capP, capPP;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle: record the sampled inputs, drive new ones, then check both phases
  task automatic cycle(input logic nR, input logic nOe, input logic [DW-1:0] nLo, input logic [DW-1:0] nHi);
    logic expEn;
    string tag;
    @(posedge clk);
    prevHi = curHi;
    capPP  = capP;
    capP   = capC;
    curLo  = loData;
    curHi  = hiData;
    curR   = rst;
    capC   = !rst && oeReq;
    #1;
    rst = nR; oeReq = nOe; loData = nLo; hiData = nHi;
    #2;
    // High phase after edge c
    expEn = !curR && capP;
    if (curR)                     tag = "R1";
    else if (!expEn && capPP)     tag = "R6";
    else if (expEn && !capPP && !capC) tag = "R7";
    else                          tag = "R4";
    chk(tag, {{(DW-1){1'b0}}, padEn}, {{(DW-1){1'b0}}, expEn});
    if (expEn) chk(capPP ? "R3" : "R8", padData, prevHi);
    @(negedge clk);
    #3;
    // Low phase after edge c + half
    expEn = !rst && capC && capP;
    if (curR || rst)              tag = "R1";
    else if (capC && !capP)       tag = "R5";
    else                          tag = "R4";
    chk(tag, {{(DW-1){1'b0}}, padEn}, {{(DW-1){1'b0}}, expEn});
    if (expEn) chk("R2", padData, curLo);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic oe;
    void'($urandom(32'h5eed_0d0e));
    curLo = '0; curHi = '0; prevHi = '0;
    curR = 1'b1; capC = 1'b0; capP = 1'b0; capPP = 1'b0;
    // R1: reset held with request high
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 8'hA5, 8'h5A);
    cycle(1'b0, 1'b0, 8'h00, 8'h00);
    cycle(1'b0, 1'b0, 8'h00, 8'h00);
    // Burst of four pairs: R5 preamble, R2/R3 ordering, R6 end
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 8'h10 + 8'(i), 8'h80 + 8'(i));
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 8'hEE, 8'hFF);
    // R7: single-cycle request
    cycle(1'b0, 1'b1, 8'h3C, 8'hC3);
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 8'h01, 8'h02);
    // R8: idle gap of one then a new burst
    cycle(1'b0, 1'b1, 8'h21, 8'h12);
    cycle(1'b0, 1'b1, 8'h22, 8'h13);
    cycle(1'b0, 1'b0, 8'h23, 8'h14);
    cycle(1'b0, 1'b1, 8'h24, 8'h15);
    cycle(1'b0, 1'b1, 8'h25, 8'h16);
    // R1: reset in the middle of a burst
    cycle(1'b1, 1'b1, 8'h26, 8'h17);
    cycle(1'b0, 1'b1, 8'h27, 8'h18);
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 8'h30 + 8'(i), 8'h40 + 8'(i));
    // Random traffic with sticky request
    oe = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (($urandom() % 4) == 0) oe = ~oe;
      cycle((($urandom() % 64) == 0), oe, 8'($urandom()), 8'($urandom()));
    end
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 8'h00, 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule